// File: doc/BRIEF.md
# Charge-Transfer Touch Acquisition Sequencer

This block is the digital sequencer of a capacitive touch controller. Once started, it repeats a two-phase burst: a charge phase followed by a transfer phase, each a programmable number of prescaled clock cycles. The burst runs on up to eight sensing groups in parallel. At the end of every transfer phase, each enabled group that is still running adds one to its own pulse counter. It also samples its comparator input, and a high level there stops that group and freezes its count.

The acquisition ends in one of three ways. It ends normally once every enabled group has stopped. It ends with an error as soon as a still-running group reaches the selected maximum pulse count. It ends as an abort when software clears the start bit. Start can begin the burst at once, or it can wait for a qualifying event on a sync pin. Two sticky flags record the outcome: end-of-acquisition and max-count-error. Each flag has its own interrupt enable, and each is cleared by writing 1 to a clear register. When the block is not acquiring, an idle-mode output tells the pad logic whether to drive the sensing IOs low or to leave them floating.

The sequencer is a five-state machine:
- IDLE moves to CHARGE in normal mode, or to SYNC_WAIT in synchronized mode.
- SYNC_WAIT moves to CHARGE on a qualifying sync event.
- CHARGE moves to TRANSFER when the high phase has run its length.
- TRANSFER moves to EVAL when the low phase has run its length.
- EVAL moves to IDLE on error or on full completion, and otherwise back to CHARGE.
- Any state moves to IDLE when the start bit drops.

Top module: `touch_acq_seq`

## Requirements
- R1: After reset, every register reads 0, both flags are 0, `irq_o` is 0, the phase outputs are 0 and `io_float_o` is 0.
- R2: Register 0 holds the control fields: bit0 on, bit1 start, bit2 sync mode, bit3 sync polarity, bit4 idle float, [7:5] prescaler code n, [11:8] high length code, [15:12] low length code and [18:16] max-count code. The charge output stays high for (high code + 1)·2^n clocks and the transfer output for (low code + 1)·2^n clocks.
- R3: At the end of each transfer phase, an enabled group that is still running increments its count. If its comparator is high at that edge, the group stops, and its count reads at address 8 + group. Its completion bit reads at bit 16 + group of register 4, and bits [7:0] of that register are the group-enable mask.
- R4: Max-count codes 0 to 6 select 255, 511, 1023, 2047, 4095, 8191 and 16383 pulses, and code 7 behaves as 16383. When a running group reaches the limit, all groups stop, register 2 bit1 (error) and bit0 (end) both set, the start bit clears, and that group's completion bit stays 0.
- R5: When every enabled group has completed, only the end flag sets and the start bit clears.
- R6: Writing the start bit to 0 during an acquisition returns the block to IDLE with both flags unchanged and the phase outputs low.
- R7: In sync mode with polarity 0, only a falling edge on `sync_in` starts the burst. A rising edge or a steady level is ignored.
- R8: In sync mode with polarity 1, a high level on `sync_in` starts the burst, and a low level holds it off.
- R9: A start request whose low length is under 3 cycles at prescaler code 0, or under 2 cycles at code 1, is refused: the start bit stays 0 and no phase runs.
- R10: Writing 1 to bit k of register 3 clears flag k. `irq_o` is (end AND register 1 bit0) OR (error AND register 1 bit1).
- R11: `io_float_o` equals the idle-float bit while the block is idle, and is 0 during an acquisition.
- R12: If a group's comparator is high on the same pulse that reaches the maximum, the group counts as completed and no error is raised.
- R13: Disabled groups never pulse, ignore their comparators, and read a count of 0 with a completion bit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |
| sync_in | input | 1 | Synchronized start pin |
| comp_in | input | 8 | Per-group comparator inputs |
| charge_o | output | 8 | Per-group charge phase |
| xfer_o | output | 8 | Per-group transfer phase |
| io_float_o | output | 1 | Idle IOs floating (1) or driven low (0) |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can happen on the same transfer-end edge: a comparator can report a touch, and the pulse counter can reach the maximum. The stimulus table provokes this by giving a group a comparator target exactly equal to the selected limit, at two different limits (255 and 511). A second group in one of those vectors overshoots, so the tie is seen both alone and next to a real error. The bench judges the result from the counts, the completion bits and the flags it reads back afterwards. A tied group must read the limit as its count, have its completion bit set, and, when it is alone, leave the error flag clear.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    localparam int CNT_W   = 14;
    localparam int PRESC_W = 3;
    localparam int PH_W    = 4;
    localparam int MAXC_W  = 3;
    localparam int DIV_W   = (1 << PRESC_W) - 1;

    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_IEN   = 4'd1;
    localparam logic [3:0] A_STAT  = 4'd2;
    localparam logic [3:0] A_CLR   = 4'd3;
    localparam logic [3:0] A_GROUP = 4'd4;
    localparam logic [3:0] A_CNT0  = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC_WAIT,
        ST_CHARGE,
        ST_TRANSFER,
        ST_EVAL
    } tsa_state_t;

    function automatic logic [CNT_W-1:0] max_of(input logic [MAXC_W-1:0] code);
        if (code >= 3'd6) return {CNT_W{1'b1}};
        return CNT_W'((32'd256 << code) - 32'd1);
    endfunction

    function automatic logic cfg_ok(input logic [PRESC_W-1:0] p, input logic [PH_W-1:0] lo);
        if (p == 3'd0 && lo < 4'd2) return 1'b0;
        if (p == 3'd1 && lo < 4'd1) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/tsa_prescaler.sv
module tsa_prescaler
    import tsa_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = DIV_W'((32'd1 << presc) - 32'd1);
        tick = (div_q == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else if (tick)    div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/tsa_group_ctr.sv
module tsa_group_ctr
    import tsa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             xfer_end,
    input  logic             comp,
    input  logic [CNT_W-1:0] max_val,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             maxed
);
    logic             running_q;
    logic [CNT_W-1:0] nxt;

    assign nxt = count + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            done      <= 1'b0;
            maxed     <= 1'b0;
            running_q <= 1'b0;
        end else if (clear) begin
            count     <= '0;
            done      <= 1'b0;
            maxed     <= 1'b0;
            running_q <= en;
        end else if (xfer_end && running_q) begin
            count <= nxt;
            if (comp) begin
                done      <= 1'b1;
                running_q <= 1'b0;
            end else if (nxt == max_val) begin
                maxed     <= 1'b1;
                running_q <= 1'b0;
            end
        end
    end

    // R3: a stopped group holds its count until the next start
    a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> $stable(count));

    // R4: a running group never reaches the limit before it stops
    a_r4_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && running_q) |-> (count < max_val));

    // R12: touch seen on the pulse wins over the limit
    a_r12_touch_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && running_q && comp && !clear) |=> (done && !maxed));
endmodule

// File: rtl/tsa_fsm.sv
module tsa_fsm
    import tsa_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            sync_mode,
    input  logic            sync_pol,
    input  logic            sync_in,
    input  logic            tick,
    input  logic [PH_W-1:0] hi_len,
    input  logic [PH_W-1:0] lo_len,
    input  logic            any_max,
    input  logic            all_done,
    output logic            restart,
    output logic            xfer_end,
    output logic            fin_ok,
    output logic            fin_err,
    output logic            ph_charge,
    output logic            ph_xfer,
    output logic            busy
);
    tsa_state_t      state_q, state_n;
    logic [PH_W-1:0] ph_q, ph_n;
    logic            sync_d;
    logic            qual;

    assign qual = sync_pol ? sync_in : (sync_d && !sync_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            sync_d  <= 1'b0;
        end else begin
            state_q <= state_n;
            ph_q    <= ph_n;
            sync_d  <= sync_in;
        end
    end

    always_comb begin
        state_n  = state_q;
        ph_n     = ph_q;
        restart  = 1'b0;
        xfer_end = 1'b0;
        fin_ok   = 1'b0;
        fin_err  = 1'b0;
        if (!run) begin
            state_n = ST_IDLE;
            ph_n    = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    ph_n = '0;
                    if (sync_mode) begin
                        state_n = ST_SYNC_WAIT;
                    end else begin
                        state_n = ST_CHARGE;
                        restart = 1'b1;
                    end
                end
                ST_SYNC_WAIT: begin
                    if (qual) begin
                        state_n = ST_CHARGE;
                        restart = 1'b1;
                        ph_n    = '0;
                    end
                end
                ST_CHARGE: begin
                    if (tick) begin
                        if (ph_q == hi_len) begin
                            state_n = ST_TRANSFER;
                            ph_n    = '0;
                        end else begin
                            ph_n = ph_q + 1'b1;
                        end
                    end
                end
                ST_TRANSFER: begin
                    if (tick) begin
                        if (ph_q == lo_len) begin
                            state_n  = ST_EVAL;
                            xfer_end = 1'b1;
                            ph_n     = '0;
                        end else begin
                            ph_n = ph_q + 1'b1;
                        end
                    end
                end
                ST_EVAL: begin
                    if (any_max) begin
                        fin_err = 1'b1;
                        state_n = ST_IDLE;
                    end else if (all_done) begin
                        fin_ok  = 1'b1;
                        state_n = ST_IDLE;
                    end else begin
                        state_n = ST_CHARGE;
                        restart = 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ph_charge = (state_q == ST_CHARGE);
        ph_xfer   = (state_q == ST_TRANSFER);
        busy      = (state_q != ST_IDLE);
    end

    // R6: dropping the start request always lands in IDLE
    a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state_q == ST_IDLE));

    // R2: a transfer phase is only ever entered from a charge phase
    a_r2_transfer_after_charge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRANSFER && $past(state_q) != ST_TRANSFER) |-> ($past(state_q) == ST_CHARGE));

    // R7: without a qualifying event the wait state holds
    a_r7_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC_WAIT && run && !qual) |=> (state_q == ST_SYNC_WAIT));
endmodule

// File: rtl/touch_acq_seq.sv
module touch_acq_seq
    import tsa_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  sync_in,
    input  logic [NUM_GROUPS-1:0] comp_in,
    output logic [NUM_GROUPS-1:0] charge_o,
    output logic [NUM_GROUPS-1:0] xfer_o,
    output logic                  io_float_o,
    output logic                  irq_o
);
    localparam int GI_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int DONE_LSB = 16;

    // control fields
    logic               on_q, start_q, smode_q, spol_q, float_q;
    logic [PRESC_W-1:0] presc_q;
    logic [PH_W-1:0]    hi_q, lo_q;
    logic [MAXC_W-1:0]  maxc_q;
    logic [1:0]         ien_q;
    logic               eoa_q, mce_q;
    logic [NUM_GROUPS-1:0] mask_q;

    logic ctrl_wr, clr_wr, start_set;
    logic tick, restart, xfer_end, fin_ok, fin_err, ph_charge, ph_xfer, busy;
    logic [CNT_W-1:0]      max_val;
    logic [CNT_W-1:0]      grp_cnt [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] done_vec, maxed_vec;
    logic [GI_W-1:0]       gsel;
    logic                  unused_bits;

    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign clr_wr    = wr_en && (wr_addr == A_CLR);
    assign start_set = ctrl_wr && !start_q && wr_data[0] && wr_data[1]
                       && cfg_ok(wr_data[7:5], wr_data[15:12]);
    assign max_val   = max_of(maxc_q);
    assign unused_bits = ^wr_data[DATA_W-1:19];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q <= 1'b0; start_q <= 1'b0; smode_q <= 1'b0; spol_q <= 1'b0;
            float_q <= 1'b0; presc_q <= '0; hi_q <= '0; lo_q <= '0; maxc_q <= '0;
            ien_q <= '0; mask_q <= '0; eoa_q <= 1'b0; mce_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                on_q <= wr_data[0];
                if (!start_q) begin
                    smode_q <= wr_data[2];
                    spol_q  <= wr_data[3];
                    float_q <= wr_data[4];
                    presc_q <= wr_data[7:5];
                    hi_q    <= wr_data[11:8];
                    lo_q    <= wr_data[15:12];
                    maxc_q  <= wr_data[18:16];
                end
            end
            if (fin_ok || fin_err)
                start_q <= 1'b0;
            else if (ctrl_wr)
                start_q <= start_q ? (wr_data[1] && wr_data[0]) : start_set;
            if (wr_en && wr_addr == A_IEN)
                ien_q <= wr_data[1:0];
            if (wr_en && wr_addr == A_GROUP && !start_q)
                mask_q <= wr_data[NUM_GROUPS-1:0];
            eoa_q <= (eoa_q && !(clr_wr && wr_data[0])) || fin_ok || fin_err;
            mce_q <= (mce_q && !(clr_wr && wr_data[1])) || fin_err;
        end
    end

    tsa_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .presc   (presc_q),
        .tick    (tick)
    );

    tsa_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (start_q && on_q),
        .sync_mode (smode_q),
        .sync_pol  (spol_q),
        .sync_in   (sync_in),
        .tick      (tick),
        .hi_len    (hi_q),
        .lo_len    (lo_q),
        .any_max   (|maxed_vec),
        .all_done  (&(done_vec | ~mask_q)),
        .restart   (restart),
        .xfer_end  (xfer_end),
        .fin_ok    (fin_ok),
        .fin_err   (fin_err),
        .ph_charge (ph_charge),
        .ph_xfer   (ph_xfer),
        .busy      (busy)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        tsa_group_ctr u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (start_set),
            .en       (mask_q[g]),
            .xfer_end (xfer_end),
            .comp     (comp_in[g]),
            .max_val  (max_val),
            .count    (grp_cnt[g]),
            .done     (done_vec[g]),
            .maxed    (maxed_vec[g])
        );
    end

    assign charge_o   = mask_q & {NUM_GROUPS{ph_charge}};
    assign xfer_o     = mask_q & {NUM_GROUPS{ph_xfer}};
    assign io_float_o = float_q && !busy;
    assign irq_o      = (eoa_q && ien_q[0]) || (mce_q && ien_q[1]);
    assign gsel       = rd_addr[GI_W-1:0];

    always_comb begin
        rd_data = '0;
        if (rd_addr >= A_CNT0) begin
            rd_data[CNT_W-1:0] = grp_cnt[gsel];
        end else begin
            case (rd_addr)
                A_CTRL:  rd_data[18:0] = {maxc_q, lo_q, hi_q, presc_q, float_q,
                                          spol_q, smode_q, start_q, on_q};
                A_IEN:   rd_data[1:0]  = ien_q;
                A_STAT:  rd_data[1:0]  = {mce_q, eoa_q};
                A_GROUP: begin
                    rd_data[NUM_GROUPS-1:0]            = mask_q;
                    rd_data[DONE_LSB +: NUM_GROUPS]    = done_vec;
                end
                default: rd_data = '0;
            endcase
        end
    end

    // R4: an error ending sets both flags and drops start
    a_r4_error_flags: assert property (@(posedge clk) disable iff (!rst_n)
        fin_err |=> (mce_q && eoa_q && !start_q));

    // R5: a clean ending sets the end flag and drops start
    a_r5_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ok |=> (eoa_q && !start_q));

    // R9: a refused start never leaves IDLE
    a_r9_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !start_q && wr_data[1] && !cfg_ok(wr_data[7:5], wr_data[15:12])) |=> !start_q);
endmodule

// File: tb/touch_acq_seq_tb_top.sv
`timescale 1ns/1ps
module touch_acq_seq_tb_top;
    localparam int NG = 8;
    localparam int NV = 6;
    localparam int VW = 118;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sync_in = 1'b0;
    logic [NG-1:0] comp_in = '0;
    logic [NG-1:0] charge_o, xfer_o;
    logic        io_float_o, irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int k [NG];
    int tgt [NG];
    logic [NG-1:0] cur_mask = '0;
    logic [NG-1:0] xp = '0;
    logic [NG-1:0] stray = '0;
    logic          seen_act = 1'b0;

    // presc, hi, lo, maxc, mask, targets g7..g0
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'd0, 4'd0, 4'd2, 3'd0, 8'hFF, 12'd1,   12'd100, 12'd30,  12'd7,   12'd2,   12'd13,  12'd9,   12'd5},
        {3'd1, 4'd1, 4'd1, 3'd0, 8'h0F, 12'd50,  12'd50,  12'd50,  12'd50,  12'd3,   12'd255, 12'd20,  12'd40},
        {3'd0, 4'd1, 4'd3, 3'd0, 8'h81, 12'd12,  12'd1,   12'd1,   12'd1,   12'd1,   12'd1,   12'd1,   12'd300},
        {3'd2, 4'd0, 4'd0, 3'd1, 8'h3C, 12'd9,   12'd9,   12'd8,   12'd600, 12'd100, 12'd511, 12'd9,   12'd9},
        {3'd0, 4'd2, 4'd2, 3'd2, 8'h10, 12'd3,   12'd3,   12'd3,   12'd1000,12'd3,   12'd3,   12'd3,   12'd3},
        {3'd0, 4'd0, 4'd2, 3'd3, 8'h40, 12'd5,   12'd2100,12'd5,   12'd5,   12'd5,   12'd5,   12'd5,   12'd5}
    };

    touch_acq_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sync_in(sync_in), .comp_in(comp_in),
        .charge_o(charge_o), .xfer_o(xfer_o), .io_float_o(io_float_o), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    function automatic int lim_of(input int mc);
        if (mc >= 6) return 16383;
        return (256 << mc) - 1;
    endfunction

    function automatic logic [31:0] cw(input bit on, input bit st, input bit sm, input bit pol,
                                       input bit fl, input int p, input int h, input int l, input int mc);
        return {13'd0, 3'(mc), 4'(l), 4'(h), 3'(p), fl, pol, sm, st, on};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        v = 32'h2;
        for (int i = 0; i < 100000 && v[1]; i++) rd(4'd0, v);
    endtask

    // comparator model: group g touches on its tgt-th transfer pulse
    initial begin
        for (int g = 0; g < NG; g++) begin k[g] = 0; tgt[g] = 4095; end
        forever begin
            @(negedge clk);
            stray    = stray | ((charge_o | xfer_o) & ~cur_mask);
            seen_act = seen_act | (|(charge_o | xfer_o));
            for (int g = 0; g < NG; g++) begin
                if (xfer_o[g] && !xp[g]) k[g]++;
                xp[g] = xfer_o[g];
                comp_in[g] = cur_mask[g] ? (k[g] >= tgt[g]) : 1'b1;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 0);
        rd(4'd2, v); chk("R1 stat", v, 0);
        rd(4'd4, v); chk("R1 group", v, 0);
        rd(4'd8, v); chk("R1 count0", v, 0);
        chk("R1 outputs", {irq_o, io_float_o, charge_o, xfer_o}, 0);

        // vector table: R3 R4 R5 R12 R13
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] e;
            int p, h, l, mc, lim;
            bit err;
            logic [NG-1:0] dn;
            e  = VEC[i];
            p  = int'(e[117:115]); h = int'(e[114:111]); l = int'(e[110:107]);
            mc = int'(e[106:104]); lim = lim_of(mc);
            wr(4'd3, 32'h3);
            wr(4'd4, {24'd0, e[103:96]});
            cur_mask = e[103:96];
            stray = '0;
            for (int g = 0; g < NG; g++) begin k[g] = 0; tgt[g] = int'(e[12*g +: 12]); end
            repeat (2) @(negedge clk);
            wr(4'd0, cw(1, 1, 0, 0, 0, p, h, l, mc));
            wait_idle();
            err = 1'b0; dn = '0;
            for (int g = 0; g < NG; g++) begin
                int ec;
                ec = 0;
                if (cur_mask[g]) begin
                    ec = (tgt[g] < lim) ? tgt[g] : lim;
                    if (tgt[g] > lim) err = 1'b1; else dn[g] = 1'b1;
                end
                rd(4'(8 + g), v);
                chk($sformatf("R3/R4/R12/R13 v%0d count g%0d", i, g), v, ec);
            end
            rd(4'd4, v);
            chk($sformatf("R3/R13 v%0d done bits", i), v, {8'd0, dn, 8'd0, cur_mask});
            rd(4'd2, v);
            chk($sformatf("R4/R5 v%0d flags", i), v, {30'd0, err, 1'b1});
            rd(4'd0, v);
            chk($sformatf("R4/R5 v%0d start cleared", i), v[1], 0);
            chk($sformatf("R13 v%0d stray pulses", i), stray, 0);
        end

        // R10: last vector ended with an error
        rd(4'd2, v); chk("R10 both flags", v, 3);
        chk("R10 irq masked", irq_o, 0);
        wr(4'd1, 32'h2); chk("R10 irq error", irq_o, 1);
        wr(4'd3, 32'h2); rd(4'd2, v); chk("R10 clear error only", v, 1);
        chk("R10 irq after clear", irq_o, 0);
        wr(4'd1, 32'h1); chk("R10 irq end", irq_o, 1);
        wr(4'd3, 32'h1); rd(4'd2, v); chk("R10 clear end", v, 0);
        chk("R10 irq off", irq_o, 0);
        wr(4'd1, 32'h0);

        // R2 phase lengths, then R6 abort
        begin
            int n;
            wr(4'd4, 32'h01); cur_mask = 8'h01;
            k[0] = 0; tgt[0] = 4095;
            wr(4'd0, cw(1, 1, 0, 0, 0, 2, 3, 1, 0));
            while (!charge_o[0]) @(negedge clk);
            n = 0;
            while (charge_o[0]) begin n++; @(negedge clk); end
            chk("R2 charge length", n, 16);
            n = 0;
            while (xfer_o[0]) begin n++; @(negedge clk); end
            chk("R2 transfer length", n, 8);
            wr(4'd0, cw(1, 0, 0, 0, 0, 2, 3, 1, 0));
            @(negedge clk);
            rd(4'd0, v); chk("R6 start dropped", v[1], 0);
            rd(4'd2, v); chk("R6 no flags", v, 0);
            chk("R6 phases low", {charge_o, xfer_o}, 0);
        end

        // R7 falling edge only
        sync_in = 1'b0;
        wr(4'd0, cw(1, 1, 1, 0, 0, 0, 0, 2, 0));
        seen_act = 1'b0;
        repeat (10) @(negedge clk);
        sync_in = 1'b1;
        repeat (20) @(negedge clk);
        chk("R7 rising edge and level ignored", seen_act, 0);
        sync_in = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 falling edge starts", seen_act, 1);
        wr(4'd0, cw(1, 0, 1, 0, 0, 0, 0, 2, 0));

        // R8 high level qualifies
        sync_in = 1'b0;
        wr(4'd0, cw(1, 1, 1, 1, 0, 0, 0, 2, 0));
        seen_act = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 low level holds", seen_act, 0);
        sync_in = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 high level starts", seen_act, 1);
        wr(4'd0, cw(1, 0, 1, 1, 0, 0, 0, 2, 0));
        sync_in = 1'b0;

        // R9 invalid low phase vs prescaler
        wr(4'd3, 32'h3);
        seen_act = 1'b0;
        wr(4'd0, cw(1, 1, 0, 0, 0, 0, 0, 1, 0));
        rd(4'd0, v); chk("R9 div1 low2 refused", v[1], 0);
        wr(4'd0, cw(1, 1, 0, 0, 0, 1, 0, 0, 0));
        rd(4'd0, v); chk("R9 div2 low1 refused", v[1], 0);
        repeat (5) @(negedge clk);
        chk("R9 no phases", seen_act, 0);
        wr(4'd0, cw(1, 1, 0, 0, 0, 1, 0, 1, 0));
        rd(4'd0, v); chk("R9 div2 low2 accepted", v[1], 1);
        wr(4'd0, cw(1, 0, 0, 0, 0, 1, 0, 1, 0));

        // R11 idle IO mode
        wr(4'd0, cw(1, 0, 0, 0, 1, 0, 0, 2, 0));
        chk("R11 float when idle", io_float_o, 1);
        wr(4'd0, cw(1, 1, 0, 0, 1, 0, 0, 2, 0));
        repeat (3) @(negedge clk);
        chk("R11 driven while busy", io_float_o, 0);
        wr(4'd0, cw(1, 0, 0, 0, 1, 0, 0, 2, 0));
        @(negedge clk);
        chk("R11 float after abort", io_float_o, 1);
        wr(4'd0, cw(1, 0, 0, 0, 0, 0, 0, 2, 0));
        chk("R11 driven low idle", io_float_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule